// File: doc/BRIEF.md
# Microprocessor System Glue Logic

This block collects the random logic that sits between a small processor with an 8-bit data bus and a 20-bit address bus and the parts around it. It splits the 1 MB address space into selects for a boot ROM, a RAM, a USB FIFO's receive and transmit data ports, two one-bit FIFO status ports and an LED output register. It acknowledges every legal bus cycle at once. It puts the selected status flag on the data bus.

It also produces the processor's interrupt priority lines and its reset and halt controls. The interrupt sources are an internal periodic tick and the FIFO's "byte waiting" flag. The tick comes from a free-running divider on the glue clock, so its rate does not follow the processor clock. The reset and halt lines are open drain. The block only ever pulls them low together, and it releases them by letting them float. A power-up hold, a debounced pushbutton and a release stretch drive that pull. The tick interrupt stays blocked for a set time after each reset release, so start-up code can install its vectors first.

Bus inputs are assumed to be stable with respect to the glue clock. The decode path is combinational and the LED register samples on the glue clock.

Top module: `sysglue_top`

## Requirements
- R1: With `as_n` low, `rom_cs_n` is low for addresses 0x00000–0x77FFF and `ram_cs_n` is low for 0x80000–0xFFFFF. At most one select, strobe or data drive is active at a time.
- R2: `fifo_rd_n` is low only for a read (`rw`=1) with `as_n` and `ds_n` low at 0x78000–0x79FFF. A write there gives no strobe and no acknowledge.
- R3: `fifo_wr_n` is low only for a write (`rw`=0) with `as_n` and `ds_n` low at 0x7A000–0x7BFFF. A read there gives no strobe and no acknowledge.
- R4: A read with `as_n` low at 0x7C000–0x7CFFF sets `data_oe` and returns the level of `fifo_rxf_n` on bit 0. A read at 0x7D000–0x7DFFF returns `fifo_txe_n` on bit 0. Bits 7:1 are zero. `data_oe` is low at every other time.
- R5: A write (`as_n`, `ds_n` low, `rw`=0) at 0x7E000–0x7FFFF loads `data_in` into `led` on that clock edge. Reset clears `led` to zero. Reads there and writes elsewhere leave `led` unchanged.
- R6: `dtack_n` is low, combinationally, while `as_n` is low and the access direction is legal for its region. ROM and RAM accept either direction. Write-only and read-only ports reject the other direction. With `as_n` high, every select, strobe, acknowledge and `data_oe` is inactive.
- R7: From reset, `cpu_rst_pull` and `cpu_halt_pull` are high for POR_CYCLES clock edges and then drop.
- R8: Pressing the button (`btn_n` low) raises both pulls once the press has been stable for DEBOUNCE_CYCLES. A shorter glitch is ignored. After release the pulls stay high at least REL_CYCLES more, and they always fall on the same edge.
- R9: The tick interrupt drives `ipl_n` = 3'b011 (level 4) for TICK_HIGH cycles in every TICK_PERIOD cycles.
- R10: While the pulls are high, `ipl_n` is 3'b111. For MASK_CYCLES after the pulls fall, the tick never shows on `ipl_n`.
- R11: `fifo_rxf_n` low drives `ipl_n` = 3'b101 (level 2), a few cycles after it changes. When the tick is also active, the tick's code wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Glue clock, independent of the processor clock |
| rst_n | input | 1 | Synchronous active-low reset of the glue logic |
| addr | input | 20 | Processor address bus |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| data_in | input | 8 | Data bus as driven by the processor |
| data_out | output | 8 | Status byte for the data bus |
| data_oe | output | 1 | Drive enable for `data_out` |
| rom_cs_n | output | 1 | ROM select, active low |
| ram_cs_n | output | 1 | RAM select, active low |
| fifo_rd_n | output | 1 | FIFO read strobe, active low |
| fifo_wr_n | output | 1 | FIFO write strobe, active low |
| fifo_rxf_n | input | 1 | FIFO flag, low when a received byte waits |
| fifo_txe_n | input | 1 | FIFO flag, low when there is room to transmit |
| dtack_n | output | 1 | Data acknowledge, active low |
| led | output | 8 | LED register contents |
| btn_n | input | 1 | Reset pushbutton, low while pressed |
| cpu_rst_pull | output | 1 | 1 = pull processor reset line low, 0 = float |
| cpu_halt_pull | output | 1 | 1 = pull processor halt line low, 0 = float |
| ipl_n | output | 3 | Interrupt priority level, active low |

## Verification
A wrong internal state shows up in one of three ways. A region decode fault shows in the same cycle as a wrong select, strobe, acknowledge or status bit for an address. A fault in the hold, debounce or mask counters moves the edge where the pulls fall, or lets a level-4 code out during the blocked window. Those faults are caught within one hold or mask period of a reset or button event. A fault in the tick divider or the priority encoder changes how many level-4 and level-2 cycles appear over a whole number of tick periods, so the bench counts codes over such windows.

// File: rtl/sysglue_pkg.sv
// sysglue_pkg: shared constants, region type and address decode function.
// Assumes a 20-bit byte address bus and an 8-bit data bus.
package sysglue_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        RG_ROM  = 3'd0,
        RG_RXD  = 3'd1,
        RG_TXD  = 3'd2,
        RG_STRX = 3'd3,
        RG_STTX = 3'd4,
        RG_LED  = 3'd5,
        RG_RAM  = 3'd6
    } region_e;

    // Map an address to its region: top half is RAM, the top 32K of the
    // lower half is I/O, everything else in the lower half is ROM.
    function automatic region_e region_of(input logic [ADDR_W-1:0] a);
        region_e r;
        if (a[19])
            r = RG_RAM;
        else if (a[18:15] != 4'hF)
            r = RG_ROM;
        else begin
            case (a[14:13])
                2'b00:   r = RG_RXD;
                2'b01:   r = RG_TXD;
                2'b10:   r = a[12] ? RG_STTX : RG_STRX;
                default: r = RG_LED;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/sysglue_decode.sv
// sysglue_decode: combinational bus decode. Produces selects, FIFO strobes,
// acknowledge, status drive and the LED write enable.
// Assumes bus inputs are stable while as_n is low.
module sysglue_decode
    import sysglue_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic              rw,
    output logic              rom_cs_n,
    output logic              ram_cs_n,
    output logic              fifo_rd_n,
    output logic              fifo_wr_n,
    output logic              dtack_n,
    output logic              stat_oe,
    output logic              stat_tx,
    output logic              led_we
);

    region_e rg;
    logic    act;
    logic    legal;

    // Region and direction legality for the current cycle.
    always_comb begin
        rg  = region_of(addr);
        act = !as_n;
        case (rg)
            RG_RXD, RG_STRX, RG_STTX: legal = rw;
            RG_TXD, RG_LED:           legal = !rw;
            default:                  legal = 1'b1;
        endcase
    end

    // Output strobes derived from region, direction and strobes.
    always_comb begin
        rom_cs_n  = !(act && rg == RG_ROM);
        ram_cs_n  = !(act && rg == RG_RAM);
        fifo_rd_n = !(act && !ds_n && rw && rg == RG_RXD);
        fifo_wr_n = !(act && !ds_n && !rw && rg == RG_TXD);
        dtack_n   = !(act && legal);
        stat_oe   = act && rw && (rg == RG_STRX || rg == RG_STTX);
        stat_tx   = (rg == RG_STTX);
        led_we    = act && !ds_n && !rw && rg == RG_LED;
    end

endmodule

// File: rtl/sysglue_resetgen.sv
// sysglue_resetgen: power-up hold, pushbutton synchroniser and debouncer,
// and release stretch. One pull flag feeds both reset and halt.
// Assumes POR_CYCLES >= REL_CYCLES.
module sysglue_resetgen #(
    parameter int POR_CYCLES      = 12_500_000,
    parameter int REL_CYCLES      = 16,
    parameter int DEBOUNCE_CYCLES = 125_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic pull
);

    localparam int HW = $clog2(POR_CYCLES + 1);
    localparam int DW = $clog2(DEBOUNCE_CYCLES + 1);

    logic          s1, s2;
    logic          db_n;
    logic [DW-1:0] db_cnt;
    logic [HW-1:0] hold;

    // Two-flop synchroniser for the button.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= btn_n;
            s2 <= s1;
        end
    end

    // Accept a new button level only after it has been stable long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_n   <= 1'b1;
            db_cnt <= '0;
        end else if (s2 == db_n) begin
            db_cnt <= '0;
        end else if (db_cnt == DW'(DEBOUNCE_CYCLES - 1)) begin
            db_n   <= s2;
            db_cnt <= '0;
        end else begin
            db_cnt <= db_cnt + 1'b1;
        end
    end

    // Hold counter: loaded at power-up and while pressed, counts down after.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= HW'(POR_CYCLES);
        else if (!db_n)
            hold <= HW'(REL_CYCLES);
        else if (hold != '0)
            hold <= hold - 1'b1;
    end

    assign pull = (hold != '0);

endmodule

// File: rtl/sysglue_tick.sv
// sysglue_tick: free-running divider on the glue clock giving a periodic
// active window of TICK_HIGH cycles in every TICK_PERIOD cycles.
// Assumes 0 < TICK_HIGH < TICK_PERIOD.
module sysglue_tick #(
    parameter int TICK_PERIOD = 1_250_000,
    parameter int TICK_HIGH   = 12_500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_on
);

    localparam int CW = $clog2(TICK_PERIOD);

    logic [CW-1:0] cnt;

    // Period counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == CW'(TICK_PERIOD - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Registered active window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_on <= 1'b0;
        else
            tick_on <= (cnt < CW'(TICK_HIGH));
    end

endmodule

// File: rtl/sysglue_irq.sv
// sysglue_irq: post-reset tick mask and priority encoder for the active-low
// interrupt level lines. Timer is level 4, FIFO receive is level 2.
// Assumes fifo_rxf_n is asynchronous and synchronises it.
module sysglue_irq #(
    parameter int MASK_CYCLES = 125_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pull,
    input  logic       tick_on,
    input  logic       fifo_rxf_n,
    output logic [2:0] ipl_n
);

    localparam int MW = $clog2(MASK_CYCLES + 1);
    localparam logic [2:0] IPL_NONE  = 3'b111;
    localparam logic [2:0] IPL_TIMER = 3'b011;
    localparam logic [2:0] IPL_FIFO  = 3'b101;

    logic          r1, r2;
    logic [MW-1:0] mask;

    // Synchronise the receive flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1 <= 1'b1;
            r2 <= 1'b1;
        end else begin
            r1 <= fifo_rxf_n;
            r2 <= r1;
        end
    end

    // Mask counter reloaded while reset is pulled, then counts down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= MW'(MASK_CYCLES);
        else if (pull)
            mask <= MW'(MASK_CYCLES);
        else if (mask != '0)
            mask <= mask - 1'b1;
    end

    // Priority encode into registered level lines.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ipl_n <= IPL_NONE;
        else if (pull)
            ipl_n <= IPL_NONE;
        else if (tick_on && mask == '0)
            ipl_n <= IPL_TIMER;
        else if (!r2)
            ipl_n <= IPL_FIFO;
        else
            ipl_n <= IPL_NONE;
    end

endmodule

// File: rtl/sysglue_top.sv
// sysglue_top: glue logic for an 8-bit-data, 20-bit-address processor board.
// Bus decode and acknowledge, FIFO status read-back, LED register, tick and
// FIFO interrupts, and open-drain reset/halt pull control.
// Assumes bus inputs are synchronous to clk around the LED write edge.
module sysglue_top
    import sysglue_pkg::*;
#(
    parameter int LED_W           = 8,
    parameter int POR_CYCLES      = 12_500_000,
    parameter int REL_CYCLES      = 16,
    parameter int DEBOUNCE_CYCLES = 125_000,
    parameter int TICK_PERIOD     = 1_250_000,
    parameter int TICK_HIGH       = 12_500,
    parameter int MASK_CYCLES     = 125_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              rom_cs_n,
    output logic              ram_cs_n,
    output logic              fifo_rd_n,
    output logic              fifo_wr_n,
    input  logic              fifo_rxf_n,
    input  logic              fifo_txe_n,
    output logic              dtack_n,
    output logic [LED_W-1:0]  led,
    input  logic              btn_n,
    output logic              cpu_rst_pull,
    output logic              cpu_halt_pull,
    output logic [2:0]        ipl_n
);

    logic stat_oe, stat_tx, led_we;
    logic pull, tick_on;

    sysglue_decode u_dec (
        .addr      (addr),
        .as_n      (as_n),
        .ds_n      (ds_n),
        .rw        (rw),
        .rom_cs_n  (rom_cs_n),
        .ram_cs_n  (ram_cs_n),
        .fifo_rd_n (fifo_rd_n),
        .fifo_wr_n (fifo_wr_n),
        .dtack_n   (dtack_n),
        .stat_oe   (stat_oe),
        .stat_tx   (stat_tx),
        .led_we    (led_we)
    );

    sysglue_resetgen #(
        .POR_CYCLES      (POR_CYCLES),
        .REL_CYCLES      (REL_CYCLES),
        .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
    ) u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .btn_n (btn_n),
        .pull  (pull)
    );

    sysglue_tick #(
        .TICK_PERIOD (TICK_PERIOD),
        .TICK_HIGH   (TICK_HIGH)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_on (tick_on)
    );

    sysglue_irq #(
        .MASK_CYCLES (MASK_CYCLES)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pull       (pull),
        .tick_on    (tick_on),
        .fifo_rxf_n (fifo_rxf_n),
        .ipl_n      (ipl_n)
    );

    // Status byte: selected flag level on bit 0, zero elsewhere.
    always_comb begin
        data_out    = '0;
        data_out[0] = stat_oe && (stat_tx ? fifo_txe_n : fifo_rxf_n);
        data_oe     = stat_oe;
    end

    // LED output register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            led <= '0;
        else if (led_we)
            led <= data_in[LED_W-1:0];
    end

    assign cpu_rst_pull  = pull;
    assign cpu_halt_pull = pull;

endmodule

// File: rtl/sysglue_chk.sv
// sysglue_chk: port-level properties of sysglue_top, bound to every instance.
module sysglue_chk #(
    parameter int LED_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             as_n,
    input logic             rw,
    input logic [7:0]       data_out,
    input logic             data_oe,
    input logic             rom_cs_n,
    input logic             ram_cs_n,
    input logic             fifo_rd_n,
    input logic             fifo_wr_n,
    input logic             dtack_n,
    input logic [LED_W-1:0] led,
    input logic             cpu_rst_pull,
    input logic             cpu_halt_pull,
    input logic [2:0]       ipl_n
);

    // R1
    single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!rom_cs_n, !ram_cs_n, !fifo_rd_n, !fifo_wr_n, data_oe}) <= 1);

    // R6
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> (rom_cs_n && ram_cs_n && fifo_rd_n && fifo_wr_n && dtack_n && !data_oe));

    // R4
    status_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (rw && !as_n && data_out[7:1] == 7'd0));

    // R5
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> $stable(led));

    // R8
    pull_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_pull == cpu_halt_pull);

    // R10
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rst_pull && $past(cpu_rst_pull)) |-> ipl_n == 3'b111);

    // R11
    ipl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ipl_n == 3'b111 || ipl_n == 3'b101 || ipl_n == 3'b011);

endmodule

bind sysglue_top sysglue_chk #(.LED_W(LED_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .as_n          (as_n),
    .rw            (rw),
    .data_out      (data_out),
    .data_oe       (data_oe),
    .rom_cs_n      (rom_cs_n),
    .ram_cs_n      (ram_cs_n),
    .fifo_rd_n     (fifo_rd_n),
    .fifo_wr_n     (fifo_wr_n),
    .dtack_n       (dtack_n),
    .led           (led),
    .cpu_rst_pull  (cpu_rst_pull),
    .cpu_halt_pull (cpu_halt_pull),
    .ipl_n         (ipl_n)
);

// File: tb/sysglue_top_tb_top.sv
`timescale 1ns/1ps
module sysglue_top_tb_top;

    localparam int POR  = 50;
    localparam int REL  = 12;
    localparam int DEB  = 4;
    localparam int PER  = 200;
    localparam int HIGH = 20;
    localparam int MASK = 100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] addr;
    logic        as_n, ds_n, rw;
    logic [7:0]  data_in;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        rom_cs_n, ram_cs_n, fifo_rd_n, fifo_wr_n;
    logic        fifo_rxf_n, fifo_txe_n;
    logic        dtack_n;
    logic [7:0]  led;
    logic        btn_n;
    logic        cpu_rst_pull, cpu_halt_pull;
    logic [2:0]  ipl_n;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    sysglue_top #(
        .LED_W(8), .POR_CYCLES(POR), .REL_CYCLES(REL), .DEBOUNCE_CYCLES(DEB),
        .TICK_PERIOD(PER), .TICK_HIGH(HIGH), .MASK_CYCLES(MASK)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .as_n(as_n), .ds_n(ds_n), .rw(rw),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .fifo_rd_n(fifo_rd_n),
        .fifo_wr_n(fifo_wr_n), .fifo_rxf_n(fifo_rxf_n), .fifo_txe_n(fifo_txe_n),
        .dtack_n(dtack_n), .led(led), .btn_n(btn_n), .cpu_rst_pull(cpu_rst_pull),
        .cpu_halt_pull(cpu_halt_pull), .ipl_n(ipl_n)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 50000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: actual cycles %0d expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected region index, by plain address comparison.
    function automatic int exp_region(input logic [19:0] a);
        if (a < 20'h78000) return 0;        // ROM
        else if (a < 20'h7A000) return 1;   // receive data
        else if (a < 20'h7C000) return 2;   // transmit data
        else if (a < 20'h7D000) return 3;   // receive status
        else if (a < 20'h7E000) return 4;   // transmit status
        else if (a < 20'h80000) return 5;   // LED
        else return 6;                      // RAM
    endfunction

    // Expected {rom,ram,rd,wr,dtack,oe,dout} for an active cycle.
    function automatic logic [13:0] exp_bus(input logic [19:0] a, input logic r,
                                            input logic d, input logic rx, input logic tx);
        int  g;
        logic ok;
        logic [7:0] db;
        g  = exp_region(a);
        ok = (g == 0 || g == 6) || ((g == 1 || g == 3 || g == 4) && r) ||
             ((g == 2 || g == 5) && !r);
        db = 8'h00;
        if (r && g == 3) db[0] = rx;
        if (r && g == 4) db[0] = tx;
        return {g != 0, g != 6, !(g == 1 && r && !d), !(g == 2 && !r && !d),
                !ok, r && (g == 3 || g == 4), db};
    endfunction

    task automatic count_ipl(input int n, output int c_t, output int c_f);
        c_t = 0;
        c_f = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ipl_n == 3'b011) c_t++;
            if (ipl_n == 3'b101) c_f++;
        end
    endtask

    initial begin
        int          ct, cf, n, hi;
        logic [13:0] e, a;
        void'($urandom(32'd4242));
        rst_n = 1'b0; addr = '0; as_n = 1'b1; ds_n = 1'b1; rw = 1'b1;
        data_in = '0; btn_n = 1'b1; fifo_rxf_n = 1'b1; fifo_txe_n = 1'b1;
        repeat (5) @(negedge clk);
        // Reset state (R7, R5, R10, R6)
        check(cpu_rst_pull && cpu_halt_pull, "R7 pulls in reset", {30'd0, cpu_rst_pull, cpu_halt_pull}, 32'h3);
        check(led == 8'h00, "R5 led reset value", led, 32'h0);
        check(ipl_n == 3'b111, "R10 ipl in reset", ipl_n, 32'h7);
        check(dtack_n && rom_cs_n && !data_oe, "R6 idle bus", {dtack_n, rom_cs_n, data_oe}, 32'h6);
        rst_n = 1'b1;

        // R7: power-up hold length
        repeat (45) @(negedge clk);
        check(cpu_rst_pull, "R7 still held at 45", cpu_rst_pull, 32'h1);
        repeat (10) @(negedge clk);
        check(!cpu_rst_pull && !cpu_halt_pull, "R7 released by 55", {cpu_rst_pull, cpu_halt_pull}, 32'h0);

        // R10: tick blocked after release
        count_ipl(90, ct, cf);
        check(ct == 0, "R10 tick masked after power-up", ct, 32'h0);

        // R1 R2 R3 R4 R6: random bus cycles
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            addr = (i % 2 == 0) ? 20'($urandom) : 20'h78000 + 20'($urandom % 32'h8000);
            rw = 1'($urandom); ds_n = 1'($urandom);
            fifo_rxf_n = 1'($urandom); fifo_txe_n = 1'($urandom);
            as_n = 1'b0;
            #1;
            e = exp_bus(addr, rw, ds_n, fifo_rxf_n, fifo_txe_n);
            a = {rom_cs_n, ram_cs_n, fifo_rd_n, fifo_wr_n, dtack_n, data_oe, data_out};
            check(a == e, "R1 R2 R3 R4 R6 bus decode", a, e);
        end
        @(negedge clk);
        as_n = 1'b1; ds_n = 1'b1; fifo_rxf_n = 1'b1; fifo_txe_n = 1'b1;
        #1;
        check(rom_cs_n && ram_cs_n && fifo_rd_n && fifo_wr_n && dtack_n && !data_oe,
              "R6 as_n high idles bus", {rom_cs_n, ram_cs_n, fifo_rd_n, fifo_wr_n, dtack_n, data_oe}, 32'h3E);

        // R2 R3 directed boundaries
        @(negedge clk); as_n = 1'b0; ds_n = 1'b0; rw = 1'b1; addr = 20'h79FFF; #1;
        check(!fifo_rd_n && !dtack_n, "R2 read at top of receive port", {fifo_rd_n, dtack_n}, 32'h0);
        rw = 1'b0; #1;
        check(fifo_rd_n && dtack_n, "R2 write to receive port rejected", {fifo_rd_n, dtack_n}, 32'h3);
        addr = 20'h7A000; #1;
        check(!fifo_wr_n && !dtack_n, "R3 write at base of transmit port", {fifo_wr_n, dtack_n}, 32'h0);
        rw = 1'b1; #1;
        check(fifo_wr_n && dtack_n, "R3 read of transmit port rejected", {fifo_wr_n, dtack_n}, 32'h3);
        addr = 20'h77FFF; #1;
        check(!rom_cs_n && ram_cs_n, "R1 top of ROM", {rom_cs_n, ram_cs_n}, 32'h1);
        addr = 20'h80000; #1;
        check(rom_cs_n && !ram_cs_n, "R1 base of RAM", {rom_cs_n, ram_cs_n}, 32'h2);
        addr = 20'h7CFFF; fifo_rxf_n = 1'b0; fifo_txe_n = 1'b1; #1;
        check(data_oe && data_out == 8'h00, "R4 receive status low", data_out, 32'h0);
        addr = 20'h7D000; #1;
        check(data_oe && data_out == 8'h01, "R4 transmit status high", data_out, 32'h1);
        fifo_rxf_n = 1'b1;

        // R5: LED writes and non-writes
        @(negedge clk); addr = 20'h7E000; rw = 1'b0; ds_n = 1'b0; data_in = 8'hA5;
        @(negedge clk); as_n = 1'b1; ds_n = 1'b1; #1;
        check(led == 8'hA5, "R5 LED write", led, 32'hA5);
        @(negedge clk); as_n = 1'b0; addr = 20'h7FFFF; rw = 1'b1; data_in = 8'h3C;
        @(negedge clk); as_n = 1'b1; #1;
        check(led == 8'hA5, "R5 LED read leaves value", led, 32'hA5);
        @(negedge clk); as_n = 1'b0; ds_n = 1'b0; addr = 20'h12345; rw = 1'b0; data_in = 8'h5A;
        @(negedge clk); as_n = 1'b1; ds_n = 1'b1; #1;
        check(led == 8'hA5, "R5 ROM write leaves LED", led, 32'hA5);
        @(negedge clk); as_n = 1'b0; ds_n = 1'b0; addr = 20'h7F001; rw = 1'b0; data_in = 8'h5A;
        @(negedge clk); as_n = 1'b1; ds_n = 1'b1; rw = 1'b1; #1;
        check(led == 8'h5A, "R5 LED second write", led, 32'h5A);

        // R9: tick rate over two whole periods
        repeat (100) @(negedge clk);
        count_ipl(2 * PER, ct, cf);
        check(ct == 2 * HIGH, "R9 level-4 cycles per two periods", ct, 2 * HIGH);
        check(cf == 0, "R11 no level-2 without data", cf, 32'h0);

        // R11: FIFO level and priority
        fifo_rxf_n = 1'b0;
        repeat (5) @(negedge clk);
        count_ipl(2 * PER, ct, cf);
        check(ct == 2 * HIGH, "R11 timer wins over FIFO", ct, 2 * HIGH);
        check(cf == 2 * (PER - HIGH), "R11 level-2 when byte waits", cf, 2 * (PER - HIGH));
        fifo_rxf_n = 1'b1;
        repeat (5) @(negedge clk);

        // R8: short glitch ignored
        btn_n = 1'b0;
        repeat (2) @(negedge clk);
        btn_n = 1'b1;
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cpu_rst_pull) hi++;
        end
        check(hi == 0, "R8 glitch ignored", hi, 32'h0);

        // R8: real press, R10 interrupts silent in reset
        btn_n = 1'b0;
        repeat (20) @(negedge clk);
        check(cpu_rst_pull && cpu_halt_pull, "R8 press pulls both", {cpu_rst_pull, cpu_halt_pull}, 32'h3);
        fifo_rxf_n = 1'b0;
        repeat (5) @(negedge clk);
        check(ipl_n == 3'b111, "R10 no interrupt during reset", ipl_n, 32'h7);
        btn_n = 1'b1;
        n = 0;
        while (cpu_rst_pull && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(n >= REL && n <= REL + DEB + 4, "R8 release stretch", n, REL + 6);

        // R10 after button release, R11 FIFO level back
        count_ipl(90, ct, cf);
        check(ct == 0, "R10 tick masked after button", ct, 32'h0);
        check(ipl_n == 3'b101, "R11 FIFO level after reset", ipl_n, 32'h5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule